// File: doc/BRIEF.md
# Bus-Activity Watchdog Supervisor

This block watches a serial peripheral bus for signs of life and pulls a reset line when the host stops talking to it. Each falling edge on the active-low chip-select input counts as bus activity and restarts an idle counter. If the counter reaches the selected time-out before the next falling edge, the block asserts its reset output for a fixed minimum width. After that width it releases the output and starts counting again.

The time-out comes from a 2-bit field held in bits 5:4 of the status word that the device's write-status command loads. Three codes pick a long, medium or short period, and the fourth code turns the supervisor off. All periods and the pulse width are parameters counted in system-clock ticks, so a simulation can scale them down. The chip-select input is asynchronous to the system clock and passes through a two-stage synchronizer before edge detection. The power-on reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `bus_wdg_supervisor`

## Requirements
- R1: After power-on reset is released, `wdt_rst_o` is low.
- R2: The select code in `stat_i[5:4]` maps as follows: 2'b00 selects `TMO_LONG` ticks, 2'b01 selects `TMO_MID` ticks, 2'b10 selects `TMO_SHORT` ticks, and 2'b11 disables the supervisor.
- R3: Suppose `cs_n_i` is first sampled low at clock edge k and no later falling edge follows. Then `wdt_rst_o` stays low through edge k+L+1 and is high after edge k+L+2, where L is the selected time-out.
- R4: Only a high-to-low transition of `cs_n_i` restarts the idle count. Falling edges spaced L cycles apart keep `wdt_rst_o` low. Holding `cs_n_i` low does not prevent a time-out, and a rising edge has no effect.
- R5: Once high, `wdt_rst_o` stays high for exactly `PULSE_TICKS` cycles and then falls. The next time-out follows L cycles later when there is no activity.
- R6: A falling edge on `cs_n_i` while `wdt_rst_o` is high neither shortens the pulse nor restarts the following idle count.
- R7: While the code is 2'b11, `wdt_rst_o` is low one edge after the code is sampled. This holds even in the middle of a pulse, and no pulse is produced however long the bus stays idle.
- R8: A change of the select code clears the idle count. With the new code sampled at edge c, the time-out fires at edge c+L_new.
- R9: Bits 7:6 and 3:0 of `stat_i` have no effect. Changing them neither restarts nor alters the time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cs_n_i | input | 1 | Bus chip select, active low, asynchronous to clk |
| stat_i | input | 8 | Status word; bits 5:4 hold the time-out select code |
| wdt_rst_o | output | 1 | Watchdog reset output, active high |

## Verification
A chip-select falling edge driven before clock edge k is first sampled at edge k. It restarts the count two edges later, so the output rises L+2 edges after k. A code change or disable takes effect at the same edge that samples it: disable drops the output one edge later, and a change produces a time-out L_new edges later. The bench numbers every rising edge with a cycle counter and records the count at which each stimulus is driven. It samples `wdt_rst_o` on the falling clock edge at both the last cycle the output must hold its old value and the first cycle it must show the new one. This brackets every expected transition to a single cycle.

// File: rtl/bus_wdg_pkg.sv
package bus_wdg_pkg;

  typedef enum logic [1:0] {
    WS_OFF  = 2'd0,
    WS_RUN  = 2'd1,
    WS_HOLD = 2'd2
  } wdg_state_e;

  localparam logic [1:0] CODE_LONG  = 2'b00;
  localparam logic [1:0] CODE_MID   = 2'b01;
  localparam logic [1:0] CODE_SHORT = 2'b10;
  localparam logic [1:0] CODE_OFF   = 2'b11;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/bus_wdg_cs_sync.sv
module bus_wdg_cs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cs_s;

  assign cs_s = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cs_n_i};
      prev_q <= cs_s;
    end
  end

  assign fall_o = prev_q & ~cs_s;

endmodule

// File: rtl/bus_wdg_limit.sv
module bus_wdg_limit
  import bus_wdg_pkg::*;
#(
  parameter int unsigned TMO_LONG  = 40,
  parameter int unsigned TMO_MID   = 24,
  parameter int unsigned TMO_SHORT = 12,
  parameter int unsigned CNT_W     = 6
) (
  input  logic [1:0]       code_i,
  output logic [CNT_W-1:0] lim_o,
  output logic             off_o
);

  always_comb begin
    off_o = 1'b0;
    unique case (code_i)
      CODE_LONG:  lim_o = CNT_W'(TMO_LONG);
      CODE_MID:   lim_o = CNT_W'(TMO_MID);
      CODE_SHORT: lim_o = CNT_W'(TMO_SHORT);
      default: begin
        lim_o = CNT_W'(TMO_SHORT);
        off_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bus_wdg_core.sv
module bus_wdg_core
  import bus_wdg_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 5,
  parameter int unsigned CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic [1:0]       code_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             off_i,
  output logic             wdt_rst_o
);

  wdg_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       code_q;
  logic             out_q, out_d;
  logic             chg;
  logic             tmo_hit;
  logic             pulse_end;

  assign chg       = (code_i != code_q);
  assign tmo_hit   = (cnt_q == (lim_i - CNT_W'(1)));
  assign pulse_end = (cnt_q == CNT_W'(PULSE_TICKS - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    out_d = out_q;
    if (off_i) begin
      st_d  = WS_OFF;
      cnt_d = '0;
      out_d = 1'b0;
    end else begin
      unique case (st_q)
        WS_OFF: begin
          st_d  = WS_RUN;
          cnt_d = '0;
          out_d = 1'b0;
        end
        WS_RUN: begin
          if (act_i || chg) begin
            cnt_d = '0;
          end else if (tmo_hit) begin
            st_d  = WS_HOLD;
            cnt_d = '0;
            out_d = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        WS_HOLD: begin
          if (pulse_end) begin
            st_d  = WS_RUN;
            cnt_d = '0;
            out_d = 1'b0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          st_d  = WS_OFF;
          cnt_d = '0;
          out_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_RUN;
      cnt_q  <= '0;
      code_q <= CODE_LONG;
      out_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      code_q <= code_i;
      out_q  <= out_d;
    end
  end

  assign wdt_rst_o = out_q;

endmodule

// File: rtl/bus_wdg_supervisor.sv
module bus_wdg_supervisor
  import bus_wdg_pkg::*;
#(
  parameter int unsigned TMO_LONG    = 70_000_000,
  parameter int unsigned TMO_MID     = 30_000_000,
  parameter int unsigned TMO_SHORT   = 10_000_000,
  parameter int unsigned PULSE_TICKS = 10_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic [7:0] stat_i,
  output logic       wdt_rst_o
);

  localparam int unsigned MAX_T = max4(TMO_LONG, TMO_MID, TMO_SHORT, PULSE_TICKS);
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             act;
  logic [1:0]       code;
  logic [CNT_W-1:0] lim;
  logic             off;
  logic             unused_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign code        = stat_i[5:4];
  assign unused_stat = ^{stat_i[7:6], stat_i[3:0]};

  bus_wdg_cs_sync #(
    .STAGES (SYNC_STAGES)
  ) u_cs_sync (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .cs_n_i (cs_n_i),
    .fall_o (act)
  );

  bus_wdg_limit #(
    .TMO_LONG  (TMO_LONG),
    .TMO_MID   (TMO_MID),
    .TMO_SHORT (TMO_SHORT),
    .CNT_W     (CNT_W)
  ) u_limit (
    .code_i (code),
    .lim_o  (lim),
    .off_o  (off)
  );

  bus_wdg_core #(
    .PULSE_TICKS (PULSE_TICKS),
    .CNT_W       (CNT_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .act_i     (act),
    .code_i    (code),
    .lim_i     (lim),
    .off_i     (off),
    .wdt_rst_o (wdt_rst_o)
  );

endmodule

// File: rtl/bus_wdg_chk.sv
module bus_wdg_chk #(
  parameter int unsigned PULSE_TICKS = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] stat_i,
  input logic       wdt_rst_o
);

  logic [1:0]  code;
  logic [31:0] hi_cnt;

  assign code = stat_i[5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (wdt_rst_o) hi_cnt <= hi_cnt + 32'd1;
    else                hi_cnt <= '0;
  end

  // R5: a pulse that ends on its own lasts exactly PULSE_TICKS cycles
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wdt_rst_o) && ($past(code) != 2'b11)) |-> (hi_cnt == 32'(PULSE_TICKS)));

  // R6: nothing but the disable code ends a pulse early
  p_pulse_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst_o && (hi_cnt < 32'(PULSE_TICKS - 1)) && (code != 2'b11)) |=> wdt_rst_o);

  // R7: the disable code forces the output low on the next edge
  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b11) |=> !wdt_rst_o);

  // R3: a pulse only starts while the supervisor is enabled
  p_rise_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> ($past(code) != 2'b11));

endmodule

bind bus_wdg_supervisor bus_wdg_chk #(
  .PULSE_TICKS (PULSE_TICKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stat_i    (stat_i),
  .wdt_rst_o (wdt_rst_o)
);

// File: tb/bus_wdg_supervisor_tb.sv
module bus_wdg_supervisor_tb;

  localparam int LT  = 40;
  localparam int MT  = 24;
  localparam int ST  = 12;
  localparam int PT  = 5;
  localparam int LAT = 3;   // drive cycle -> sample edge (1) + restart latency (2)

  logic       clk;
  logic       rst_n;
  logic       cs_n;
  logic [7:0] stat;
  logic       wrst;

  int cyc;
  int checks;
  int fails;
  bit done;

  bus_wdg_supervisor #(
    .TMO_LONG    (LT),
    .TMO_MID     (MT),
    .TMO_SHORT   (ST),
    .PULSE_TICKS (PT)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n),
    .stat_i    (stat),
    .wdt_rst_o (wrst)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic exp);
    checks++;
    if (wrst !== exp) begin
      fails++;
      $display("FAIL %s: wdt_rst_o=%0b expected %0b at cycle %0d", req, wrst, exp, cyc);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic kick(output int t0);
    t0   = cyc;
    cs_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic prep(input logic [1:0] c);
    stat = 8'h30;
    repeat (2) @(negedge clk);
    stat = {2'b00, c, 4'h0};
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cs_n  = 1'b1;
    stat  = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset", 1'b0);
  endtask

  task automatic t_codes;
    int t0;
    int lim;
    for (int c = 0; c < 3; c++) begin
      lim = (c == 0) ? LT : (c == 1) ? MT : ST;
      prep(2'(c));
      kick(t0);
      wait_to(t0 + lim + LAT - 1);
      chk("R2/R3 before time-out", 1'b0);
      wait_to(t0 + lim + LAT);
      chk("R2/R3 at time-out", 1'b1);
    end
  endtask

  task automatic t_pulse;
    int t0;
    int e;
    prep(2'b10);
    kick(t0);
    e = t0 + ST + LAT;
    wait_to(e);            chk("R5 pulse start", 1'b1);
    wait_to(e + PT - 1);   chk("R5 pulse last cycle", 1'b1);
    wait_to(e + PT);       chk("R5 pulse end", 1'b0);
    wait_to(e + PT + ST - 1); chk("R5 recount before", 1'b0);
    wait_to(e + PT + ST);  chk("R5 second time-out", 1'b1);
  endtask

  task automatic t_kick_train;
    int t0;
    int bad;
    bad = 0;
    prep(2'b10);
    for (int i = 0; i < 6; i++) begin
      kick(t0);
      while (cyc < t0 + ST) begin
        if (wrst !== 1'b0) bad++;
        @(negedge clk);
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R4 kick train: %0d high cycles expected 0", bad);
    end
    wait_to(t0 + ST + LAT - 1); chk("R4 after train before", 1'b0);
    wait_to(t0 + ST + LAT);     chk("R4 after train time-out", 1'b1);
  endtask

  task automatic t_held_low;
    int t0;
    int e;
    prep(2'b10);
    t0   = cyc;
    cs_n = 1'b0;
    e    = t0 + ST + LAT;
    wait_to(e - 1); chk("R4 held low before", 1'b0);
    wait_to(e);     chk("R4 held low time-out", 1'b1);
    wait_to(e + PT + 2);
    cs_n = 1'b1;
    wait_to(e + PT + ST - 1); chk("R4 rising edge ignored before", 1'b0);
    wait_to(e + PT + ST);     chk("R4 rising edge ignored time-out", 1'b1);
  endtask

  task automatic t_pulse_kick;
    int t0;
    int t1;
    int e;
    prep(2'b10);
    kick(t0);
    e = t0 + ST + LAT;
    wait_to(e + 1);
    kick(t1);
    wait_to(e + PT - 1);      chk("R6 pulse held", 1'b1);
    wait_to(e + PT);          chk("R6 pulse end", 1'b0);
    wait_to(e + PT + ST - 1); chk("R6 count not restarted before", 1'b0);
    wait_to(e + PT + ST);     chk("R6 count not restarted", 1'b1);
  endtask

  task automatic t_disable;
    int t0;
    int c1;
    int bad;
    bad = 0;
    prep(2'b10);
    kick(t0);
    wait_to(t0 + ST + LAT + 1);
    chk("R7 pulse before disable", 1'b1);
    c1   = cyc;
    stat = 8'h30;
    wait_to(c1 + 1);
    chk("R7 disable drops output", 1'b0);
    while (cyc < c1 + 3 * LT) begin
      if (wrst !== 1'b0) bad++;
      @(negedge clk);
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R7 disabled idle: %0d high cycles expected 0", bad);
    end
  endtask

  task automatic t_change;
    int t0;
    int c1;
    prep(2'b10);
    kick(t0);
    wait_to(t0 + 6);
    c1   = cyc;
    stat = 8'h10;
    wait_to(t0 + ST + LAT); chk("R8 old period cleared", 1'b0);
    wait_to(c1 + MT);       chk("R8 new period before", 1'b0);
    wait_to(c1 + MT + 1);   chk("R8 new period time-out", 1'b1);
  endtask

  task automatic t_other_bits;
    int t0;
    prep(2'b10);
    kick(t0);
    wait_to(t0 + 5);
    stat = 8'hEF;
    wait_to(t0 + ST + LAT - 1); chk("R9 other bits before", 1'b0);
    wait_to(t0 + ST + LAT);     chk("R9 other bits time-out", 1'b1);
  endtask

  initial begin
    clk    = 1'b0;
    rst_n  = 1'b0;
    cs_n   = 1'b1;
    stat   = 8'h00;
    cyc    = 0;
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    @(negedge clk);
    t_reset();
    t_codes();
    t_pulse();
    t_kick_train();
    t_held_low();
    t_pulse_kick();
    t_disable();
    t_change();
    t_other_bits();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run incomplete at cycle %0d expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule